// File: doc/BRIEF.md
# Clock Synthesizer Reprogramming Sequencer

This block drives the memory-mapped register port of a clock synthesizer's reconfiguration controller. When `start` is pulsed it writes a stored set of divider, counter and loop settings into the controller in a fixed order. It then reads every one of those registers back and compares each value with the one it meant to write. If they all match, it writes the commit register, holds the synthesizer in reset for one millisecond and waits one more millisecond for the loop to settle. Finally it watches the lock input until lock has stayed high for a programmable number of consecutive cycles.

A brief lock that drops again does not count as success. Only an unbroken run of the programmed length does. A watchdog limits how long the sequencer waits for lock. Each run ends with a single-cycle `done` pulse and a result code. The result code separates three outcomes: a controller that did not keep what was written, a loop that never locked, and success.

The millisecond interval comes from a reference clock frequency parameter. A shortened interval can be selected for simulation.

Top module: `pll_reprog_seq`

## Requirements
- R1: Parameter writes go out in this order: feedback divider `par_m` at address 0x90, then input divider `par_n` at 0xA0, then output counter i (`par_c` bits [i*DW +: DW]) at 0xC0+i for ascending i, then charge pump `par_cp` at 0x20, then loop filter `par_lf` at 0x40.
- R2: With `stepwise`=1, a commit write (address 0, data 0) follows the input-divider write and also follows each output-counter write. With `stepwise`=0 no intermediate commit is issued. After a clean readback, exactly one final commit is written.
- R3: While `bus_waitrequest` is high during an access, address, writedata, write and read hold their values. An access completes on a cycle with `bus_waitrequest` low. Read and write are never high together.
- R4: After the parameter writes, every parameter register is read back in the R1 order. If any readback value differs, the run ends with status 2 (mismatch), with no final commit and no reset pulse.
- R5: After the final commit, `pll_rst` is high for exactly MS_TICKS cycles. A settling window of MS_TICKS cycles follows, and lock is ignored during it.
- R6: Success needs `pll_locked` high for `qual_cycles` consecutive cycles in the lock phase. Counting from the first cycle of `pll_rst`, `done` then rises 2*MS_TICKS+`qual_cycles` cycles later, with status 1.
- R7: A drop of lock restarts the qualification count, so a lock pulse shorter than `qual_cycles` never produces success.
- R8: If WDOG_TICKS cycles of the lock phase pass without qualification, the run ends with status 3 (timeout) and the block returns to idle.
- R9: A `start` pulse while `busy` is high is ignored and causes no second program.
- R10: `done` is high for one cycle. `status` is cleared on an accepted start and holds the result until the next accepted start. `fail` is high while the held status is 2 or 3.
- R11: After reset the block is idle, with `busy`, `done`, `pll_rst`, `fail`, bus write and bus read low and `status` 0.
- R12: A `qual_cycles` value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a reprogramming run when idle |
| stepwise | input | 1 | Insert intermediate commit writes |
| par_m | input | DW | Feedback divider setting |
| par_n | input | DW | Input divider setting |
| par_c | input | NUM_CNT*DW | Output counter settings, counter i in bits [i*DW +: DW] |
| par_cp | input | DW | Charge pump setting |
| par_lf | input | DW | Loop filter setting |
| qual_cycles | input | QW | Consecutive lock cycles needed for success |
| bus_address | output | AW | Register address |
| bus_write | output | 1 | Write request |
| bus_writedata | output | DW | Write data |
| bus_read | output | 1 | Read request |
| bus_readdata | input | DW | Read data, valid when waitrequest is low |
| bus_waitrequest | input | 1 | Controller stall |
| pll_locked | input | 1 | Synthesizer lock indication |
| pll_rst | output | 1 | Synthesizer reset |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 2 | 0 none, 1 success, 2 readback mismatch, 3 lock timeout |
| fail | output | 1 | Held status is a failure |

## Verification
The hardest case to reach from the ports is a lock that comes up, drops and later returns. The drop has to fall inside the lock phase, after the reset and settling windows, so the bench can only place it relative to the `pll_rst` pulse it observes. The bench models lock as a function of the cycle distance from the first `pll_rst` cycle. That lets it place glitches shorter than the qualification window, lock that exists only during settling, and lock that returns after a gap. The expected `done` cycle is computed from that distance, and every lock pattern is swept against each commit mode and each waitrequest pattern (never, alternating, pseudo-random). A register that reads back wrong is produced by flipping a bit in the modelled controller's read path.

// File: rtl/pll_reprog_pkg.sv
package pll_reprog_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WR,
        S_MIDC,
        S_RD,
        S_COMMIT,
        S_RST,
        S_SETTLE,
        S_LOCK,
        S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        RES_NONE     = 2'd0,
        RES_OK       = 2'd1,
        RES_MISMATCH = 2'd2,
        RES_TIMEOUT  = 2'd3
    } seq_result_e;

    localparam int unsigned OFS_COMMIT = 32'h00;
    localparam int unsigned OFS_PUMP   = 32'h20;
    localparam int unsigned OFS_FILT   = 32'h40;
    localparam int unsigned OFS_FBDIV  = 32'h90;
    localparam int unsigned OFS_INDIV  = 32'hA0;
    localparam int unsigned OFS_CNT0   = 32'hC0;

endpackage

// File: rtl/pll_reprog_timer.sv
module pll_reprog_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pll_reprog_lockq.sv
module pll_reprog_lockq #(
    parameter int unsigned QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          en,
    input  logic          locked,
    input  logic [QW-1:0] qual,
    output logic          met
);
    logic [QW:0] run_d, run_q;
    logic [QW:0] need;

    always_comb begin
        need  = (qual == '0) ? (QW+1)'(1) : {1'b0, qual};
        met   = en && locked && ((run_q + (QW+1)'(1)) >= need);
        run_d = run_q + (QW+1)'(1);
        if (clear || !en || !locked || met) begin
            run_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_reprog_pkg::*;
#(
    parameter int unsigned DW            = 32,
    parameter int unsigned AW            = 9,
    parameter int unsigned NUM_CNT       = 2,
    parameter int unsigned QW            = 16,
    parameter int unsigned CLK_KHZ       = 100000,
    parameter bit          FAST_SIM      = 1'b0,
    parameter int unsigned FAST_MS_TICKS = 16,
    parameter int unsigned WDOG_TICKS    = 500000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  stepwise,
    input  logic [DW-1:0]         par_m,
    input  logic [DW-1:0]         par_n,
    input  logic [NUM_CNT*DW-1:0] par_c,
    input  logic [DW-1:0]         par_cp,
    input  logic [DW-1:0]         par_lf,
    input  logic [QW-1:0]         qual_cycles,
    output logic [AW-1:0]         bus_address,
    output logic                  bus_write,
    output logic [DW-1:0]         bus_writedata,
    output logic                  bus_read,
    input  logic [DW-1:0]         bus_readdata,
    input  logic                  bus_waitrequest,
    input  logic                  pll_locked,
    output logic                  pll_rst,
    output logic                  busy,
    output logic                  done,
    output logic [1:0]            status,
    output logic                  fail
);
    localparam int unsigned MS_TICKS = FAST_SIM ? FAST_MS_TICKS : CLK_KHZ;
    localparam int unsigned TMAX     = (MS_TICKS > WDOG_TICKS) ? MS_TICKS : WDOG_TICKS;
    localparam int unsigned TW       = $clog2(TMAX + 1);
    localparam int unsigned NSLOT    = NUM_CNT + 4;
    localparam int unsigned SW       = $clog2(NSLOT + 1);
    localparam int unsigned SLOT_CP  = NUM_CNT + 2;

    typedef struct packed {
        seq_state_e  st;
        logic [SW-1:0] slot;
        logic        miss;
        seq_result_e res;
    } seq_regs_t;

    seq_regs_t d, q;

    logic [AW-1:0] slot_addr [NSLOT];
    logic [DW-1:0] slot_val  [NSLOT];

    assign slot_addr[0] = AW'(OFS_FBDIV);
    assign slot_val[0]  = par_m;
    assign slot_addr[1] = AW'(OFS_INDIV);
    assign slot_val[1]  = par_n;
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        assign slot_addr[2+i] = AW'(OFS_CNT0 + i);
        assign slot_val[2+i]  = par_c[i*DW +: DW];
    end
    assign slot_addr[SLOT_CP]   = AW'(OFS_PUMP);
    assign slot_val[SLOT_CP]    = par_cp;
    assign slot_addr[SLOT_CP+1] = AW'(OFS_FILT);
    assign slot_val[SLOT_CP+1]  = par_lf;

    logic          ivl_load, ivl_zero;
    logic          wd_load, wd_zero;
    logic [TW-1:0] ivl_val, wd_val;
    logic          lq_clear, lq_met;

    pll_reprog_timer #(.W(TW)) u_ivl (
        .clk(clk), .rst_n(rst_n), .load(ivl_load), .load_val(ivl_val), .zero(ivl_zero)
    );

    pll_reprog_timer #(.W(TW)) u_wdog (
        .clk(clk), .rst_n(rst_n), .load(wd_load), .load_val(wd_val), .zero(wd_zero)
    );

    pll_reprog_lockq #(.QW(QW)) u_lockq (
        .clk(clk), .rst_n(rst_n), .clear(lq_clear), .en(q.st == S_LOCK),
        .locked(pll_locked), .qual(qual_cycles), .met(lq_met)
    );

    logic slot_last, slot_mid, rd_bad;

    always_comb begin
        d             = q;
        ivl_load      = 1'b0;
        ivl_val       = TW'(MS_TICKS - 1);
        wd_load       = 1'b0;
        wd_val        = TW'(WDOG_TICKS - 1);
        lq_clear      = 1'b0;
        bus_address   = '0;
        bus_write     = 1'b0;
        bus_read      = 1'b0;
        bus_writedata = '0;
        slot_last     = (q.slot == SW'(NSLOT - 1));
        slot_mid      = (q.slot >= SW'(1)) && (q.slot <= SW'(NUM_CNT + 1));
        rd_bad        = 1'b0;

        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.st   = S_WR;
                    d.slot = '0;
                    d.miss = 1'b0;
                    d.res  = RES_NONE;
                end
            end
            S_WR: begin
                bus_address   = slot_addr[q.slot];
                bus_writedata = slot_val[q.slot];
                bus_write     = 1'b1;
                if (!bus_waitrequest) begin
                    if (stepwise && slot_mid) begin
                        d.st = S_MIDC;
                    end else if (slot_last) begin
                        d.st   = S_RD;
                        d.slot = '0;
                    end else begin
                        d.slot = q.slot + SW'(1);
                    end
                end
            end
            S_MIDC: begin
                bus_address = AW'(OFS_COMMIT);
                bus_write   = 1'b1;
                if (!bus_waitrequest) begin
                    d.st   = S_WR;
                    d.slot = q.slot + SW'(1);
                end
            end
            S_RD: begin
                bus_address = slot_addr[q.slot];
                bus_read    = 1'b1;
                if (!bus_waitrequest) begin
                    rd_bad = (bus_readdata != slot_val[q.slot]);
                    d.miss = q.miss | rd_bad;
                    if (slot_last) begin
                        if (q.miss | rd_bad) begin
                            d.st  = S_DONE;
                            d.res = RES_MISMATCH;
                        end else begin
                            d.st = S_COMMIT;
                        end
                    end else begin
                        d.slot = q.slot + SW'(1);
                    end
                end
            end
            S_COMMIT: begin
                bus_address = AW'(OFS_COMMIT);
                bus_write   = 1'b1;
                if (!bus_waitrequest) begin
                    d.st     = S_RST;
                    ivl_load = 1'b1;
                end
            end
            S_RST: begin
                if (ivl_zero) begin
                    d.st     = S_SETTLE;
                    ivl_load = 1'b1;
                end
            end
            S_SETTLE: begin
                if (ivl_zero) begin
                    d.st     = S_LOCK;
                    wd_load  = 1'b1;
                    lq_clear = 1'b1;
                end
            end
            S_LOCK: begin
                if (lq_met) begin
                    d.st  = S_DONE;
                    d.res = RES_OK;
                end else if (wd_zero) begin
                    d.st  = S_DONE;
                    d.res = RES_TIMEOUT;
                end
            end
            S_DONE: begin
                d.st = S_IDLE;
            end
            default: begin
                d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= S_IDLE;
            q.slot <= '0;
            q.miss <= 1'b0;
            q.res  <= RES_NONE;
        end else begin
            q <= d;
        end
    end

    assign pll_rst = (q.st == S_RST);
    assign busy    = (q.st != S_IDLE);
    assign done    = (q.st == S_DONE);
    assign status  = q.res;
    assign fail    = (q.res == RES_MISMATCH) || (q.res == RES_TIMEOUT);
endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk #(
    parameter int unsigned AW = 9,
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          pll_rst,
    input logic          pll_locked,
    input logic          bus_write,
    input logic          bus_read,
    input logic          bus_waitrequest,
    input logic [AW-1:0] bus_address,
    input logic [DW-1:0] bus_writedata,
    input logic [1:0]    status
);
    assert_bus_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_write || bus_read) && bus_waitrequest |=>
            $stable(bus_address) && $stable(bus_writedata) && $stable(bus_write) && $stable(bus_read));

    assert_no_rw_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_write && bus_read));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status != 2'd0));

    assert_rst_quiet_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst |-> !bus_write && !bus_read);

    assert_rst_then_settle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_rst) |-> busy && !done);

    assert_ok_after_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) && (status == 2'd1) |-> $past(pll_locked));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_write && !bus_read && !pll_rst);
endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .pll_rst(pll_rst),
    .pll_locked(pll_locked), .bus_write(bus_write), .bus_read(bus_read),
    .bus_waitrequest(bus_waitrequest), .bus_address(bus_address),
    .bus_writedata(bus_writedata), .status(status)
);

// File: tb/pll_reprog_seq_tb.sv
`timescale 1ns/1ps
module pll_reprog_seq_tb;
    localparam int NC = 2;
    localparam int MT = 6;
    localparam int WD = 40;
    localparam int GL = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic stepwise = 1'b0;
    logic [31:0] par_m = '0, par_n = '0, par_cp = '0, par_lf = '0;
    logic [NC*32-1:0] par_c = '0;
    logic [7:0] qual_cycles = 8'd5;
    logic [8:0] bus_address;
    logic bus_write, bus_read, pll_rst, busy, done, fail;
    logic [31:0] bus_writedata, bus_readdata;
    logic bus_waitrequest = 1'b0;
    logic pll_locked = 1'b0;
    logic [1:0] status;

    always #2.5 clk = ~clk;

    pll_reprog_seq #(
        .DW(32), .AW(9), .NUM_CNT(NC), .QW(8), .CLK_KHZ(200000),
        .FAST_SIM(1'b1), .FAST_MS_TICKS(MT), .WDOG_TICKS(WD)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stepwise(stepwise),
        .par_m(par_m), .par_n(par_n), .par_c(par_c), .par_cp(par_cp), .par_lf(par_lf),
        .qual_cycles(qual_cycles), .bus_address(bus_address), .bus_write(bus_write),
        .bus_writedata(bus_writedata), .bus_read(bus_read), .bus_readdata(bus_readdata),
        .bus_waitrequest(bus_waitrequest), .pll_locked(pll_locked), .pll_rst(pll_rst),
        .busy(busy), .done(done), .status(status), .fail(fail)
    );

    int checks = 0, fails = 0;
    int cyc = 0;
    logic [31:0] regs [512];
    int wlog_a [1024];
    int wlog_d [1024];
    int rlog_a [1024];
    int wr_n = 0, rd_n = 0;
    int rise_cnt = 0, rise_base = 0, t_rise = 0, rst_len = 0;
    int done_cnt = 0, t_done = 0, dbl_cnt = 0;
    int last_status = 0;
    bit rst_prev = 0, done_prev = 0;
    int lock_mode = 0, wmode = 0;
    int corrupt_addr = -1;
    int rel = 0;
    logic [7:0] lfsr = 8'hA5;

    always_comb begin
        bus_readdata = regs[bus_address];
        if (int'(bus_address) == corrupt_addr) bus_readdata = bus_readdata ^ 32'h1;
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst_n && bus_write && !bus_waitrequest) begin
            regs[bus_address] = bus_writedata;
            wlog_a[wr_n % 1024] = int'(bus_address);
            wlog_d[wr_n % 1024] = int'(bus_writedata);
            wr_n = wr_n + 1;
        end
        if (rst_n && bus_read && !bus_waitrequest) begin
            rlog_a[rd_n % 1024] = int'(bus_address);
            rd_n = rd_n + 1;
        end
    end

    always @(negedge clk) begin
        if (pll_rst && !rst_prev) begin
            rise_cnt = rise_cnt + 1;
            t_rise = cyc;
        end
        rst_prev = pll_rst;
        if (pll_rst) rst_len = rst_len + 1;
        if (done) begin
            done_cnt = done_cnt + 1;
            t_done = cyc;
            last_status = int'(status);
            if (done_prev) dbl_cnt = dbl_cnt + 1;
        end
        done_prev = done;
        rel = cyc - t_rise;
        if (rise_cnt <= rise_base) pll_locked = 1'b0;
        else begin
            case (lock_mode)
                0: pll_locked = (rel >= MT);
                2: pll_locked = (rel >= 2*MT) && (rel < 2*MT + GL);
                3: pll_locked = ((rel >= 2*MT) && (rel < 2*MT + GL)) || (rel >= 2*MT + GL + 3);
                4: pll_locked = (rel >= MT) && (rel < 2*MT);
                default: pll_locked = 1'b0;
            endcase
        end
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (wmode)
            1: bus_waitrequest = ~bus_waitrequest;
            2: bus_waitrequest = lfsr[0];
            default: bus_waitrequest = 1'b0;
        endcase
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // sc: 0 ok, 1 never locks, 2 glitch then none, 3 glitch then solid,
    //     4 lock only while settling, 5 loop filter reads back wrong, 6 feedback divider reads back wrong
    task automatic run_case(input int id, input int sw, input int wm, input int sc, input int q);
        int exp_a [32];
        int exp_d [32];
        int n, wbase, rbase, dbase, lbase, dblbase, qe, exp_st, exp_dt;
        bit mism, ok;
        @(negedge clk);
        stepwise = sw[0];
        wmode = wm;
        qual_cycles = 8'(q);
        par_m = 32'h1000 + 32'(id * 16) + 32'd1;
        par_n = 32'h2000 + 32'(id * 16) + 32'd2;
        for (int i = 0; i < NC; i++) par_c[i*32 +: 32] = 32'h0A00 + 32'(id * 8) + 32'(i);
        par_cp = 32'h3000 + 32'(id);
        par_lf = 32'h4000 + 32'(id);
        mism = (sc == 5) || (sc == 6);
        corrupt_addr = (sc == 5) ? 32'h40 : (sc == 6) ? 32'h90 : -1;
        lock_mode = (sc == 0 || sc >= 5) ? 0 : sc;
        rise_base = rise_cnt;
        wbase = wr_n; rbase = rd_n; dbase = done_cnt; lbase = rst_len; dblbase = dbl_cnt;
        // expected program per R1/R2
        n = 0;
        exp_a[n] = 32'h90; exp_d[n] = int'(par_m); n++;
        exp_a[n] = 32'hA0; exp_d[n] = int'(par_n); n++;
        if (sw != 0) begin exp_a[n] = 0; exp_d[n] = 0; n++; end
        for (int i = 0; i < NC; i++) begin
            exp_a[n] = 32'hC0 + i; exp_d[n] = int'(par_c[i*32 +: 32]); n++;
            if (sw != 0) begin exp_a[n] = 0; exp_d[n] = 0; n++; end
        end
        exp_a[n] = 32'h20; exp_d[n] = int'(par_cp); n++;
        exp_a[n] = 32'h40; exp_d[n] = int'(par_lf); n++;
        if (!mism) begin exp_a[n] = 0; exp_d[n] = 0; n++; end

        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
        chk(status == 2'd0, "R10 status cleared on start", int'(status), 0);
        repeat (3) @(negedge clk);
        start = 1'b1;            // R9: must be ignored
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 3000 && done_cnt == dbase; k++) @(negedge clk);
        chk(done_cnt > dbase, "R8 run terminates", done_cnt - dbase, 1);
        repeat (12) @(negedge clk);

        chk(wr_n - wbase == n, "R1/R2 write count", wr_n - wbase, n);
        for (int i = 0; i < n && i < wr_n - wbase; i++) begin
            ok = (wlog_a[(wbase + i) % 1024] == exp_a[i]) && (wlog_d[(wbase + i) % 1024] == exp_d[i]);
            chk(ok, "R1 R2 write entry address", wlog_a[(wbase + i) % 1024], exp_a[i]);
        end
        ok = (rd_n - rbase == NC + 4);
        for (int i = 0; i < NC + 4 && ok; i++) begin
            qe = (i == 0) ? 32'h90 : (i == 1) ? 32'hA0 : (i < NC + 2) ? 32'hC0 + i - 2 :
                 (i == NC + 2) ? 32'h20 : 32'h40;
            if (rlog_a[(rbase + i) % 1024] != qe) ok = 0;
        end
        chk(ok, "R4 readback order", rd_n - rbase, NC + 4);
        chk(done_cnt - dbase == 1, "R9 single run per accepted start", done_cnt - dbase, 1);
        chk(dbl_cnt == dblbase, "R10 done one cycle", dbl_cnt - dblbase, 0);
        chk(busy == 1'b0, "R8 back to idle", int'(busy), 0);

        qe = (q == 0) ? 1 : q;
        if (mism) begin
            exp_st = 2;
            exp_dt = 0;
        end else if (sc == 0) begin
            exp_st = 1; exp_dt = 2*MT + qe;
        end else if (sc == 3) begin
            exp_st = 1; exp_dt = 2*MT + GL + 3 + qe;
        end else begin
            exp_st = 3; exp_dt = 2*MT + WD;
        end
        chk(last_status == exp_st, "R4 R6 R7 R8 status at done", last_status, exp_st);
        chk(int'(status) == exp_st, "R10 status held", int'(status), exp_st);
        chk(fail == (exp_st != 1), "R10 fail flag", int'(fail), int'(exp_st != 1));
        if (mism) begin
            chk(rise_cnt == rise_base, "R4 no reset pulse on mismatch", rise_cnt - rise_base, 0);
        end else begin
            chk(rst_len - lbase == MT, "R5 reset pulse width", rst_len - lbase, MT);
            chk(t_done - t_rise == exp_dt, "R5 R6 R7 R12 done timing", t_done - t_rise, exp_dt);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
        $finish;
    end

    initial begin
        int id;
        for (int i = 0; i < 512; i++) regs[i] = '0;
        repeat (4) @(negedge clk);
        chk(!busy && !done && !pll_rst && !fail && !bus_write && !bus_read && status == 2'd0,
            "R11 state during reset", int'(busy), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !pll_rst && !fail && !bus_write && !bus_read && status == 2'd0,
            "R11 idle after reset", int'(busy), 0);
        id = 0;
        for (int sw = 0; sw < 2; sw++)
            for (int wm = 0; wm < 3; wm++)
                for (int sc = 0; sc < 7; sc++) begin
                    run_case(id, sw, wm, sc, 5);
                    id++;
                end
        run_case(id, 0, 0, 0, 0); id++;   // R12 zero window
        run_case(id, 1, 2, 0, 0); id++;   // R12
        run_case(id, 1, 2, 3, 9); id++;   // R7 with wider window
        run_case(id, 0, 1, 2, 9); id++;   // R7 glitch timeout
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule